// File: doc/BRIEF.md
# PLL Programming Sequencer

This block replaces a boot-time software routine that brings up a single PLL. After a one-cycle start pulse it captures a configuration: reference pre-divider, feedback multiplier, output post-divider, the base address of the PLL's register window, a flag that marks the fractional-capable PLL variant, and a poll limit. It then works out the oscillator (DCO) frequency, the speed-range code and the sigma-delta value. A multi-cycle restoring divider does the divisions.

Once the arithmetic is finished, the sequencer drives the PLL through a fixed script on a single-outstanding request/ready register bus. The script has four parts:
- It puts the PLL into bypass and waits for the bypass acknowledge.
- It drops the init bit and loads the dividers.
- For the fractional variant only, it adds the sigma-delta value, the speed code and the output-enable bits.
- It pulses the two load strobes, releases bypass, and waits for phase and frequency lock.

Every status wait is bounded by the poll limit. The block reports `busy` while it runs and ends with a one-cycle `done` or `err` pulse.

Top module: `pll_prog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `bus_req` are all 0.
- R2: A `start` pulse while idle latches the configuration and raises `busy` on the next clock. A `start` while busy is ignored: the configuration and the bus script in progress do not change.
- R3: DCO = (20 integer-divided by (N+1)) × M. A DCO in [500,1000) selects speed code 0x801. A DCO in [1000,2000) selects 0x1001. For the fractional variant, any other DCO gives `err` with no bus transfer at all. For the plain variant the range is not checked.
- R4: The sigma-delta value is floor((DCO+225)/250), the same as floor(DCO/250+0.9). It is written into bits [31:24] of the fractional register at base+0x18, and the other bits are 0.
- R5: The first transfer reads control (base+0x04). The second writes back that value with bit 23 set. Status (base+0x24) is then read until bits 8 and 0 are both 1.
- R6: Next the sequencer writes control with bit 0 cleared. It then writes base+0x10 with M2 in [31:16] and N in the low bits, then writes M to base+0x14. All later control writes start from this kept copy of control, with no further reads.
- R7: For the fractional variant only, the sequencer next writes the fractional register. It then writes control with bits 12, 11 and 10 cleared and the speed code ORed in.
- R8: Next it writes base+0x0C with 1 and then 0xFFFFFFFE. After that it writes base+0x08 with 1 and then 0xFFFFFFFE.
- R9: For the fractional variant only, it then writes control with bits 29, 20, 19 and 17 set. Last, it writes control with bit 23 cleared and bit 0 set, and reads status until bits 10 and 9 are both 1. `done` then pulses.
- R10: A status wait gives up after max(limit,1) consecutive reads that fail its test. The block then pulses `err`, goes idle and issues no further transfers.
- R11: `bus_req` stays high, with address, data and direction held, until `bus_ready`. It is low while the block is idle.
- R12: `done` and `err` are one-cycle pulses, never both high. `busy` is 0 in the cycle either one is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin programming |
| cfg_n | input | NW | Reference pre-divider N |
| cfg_m | input | MW | Feedback multiplier M |
| cfg_m2 | input | M2W | Output post-divider M2 |
| cfg_base | input | AW | Base address of the PLL register window |
| cfg_frac | input | 1 | 1 = fractional-capable PLL variant |
| cfg_limit | input | TW | Maximum failed status reads per wait |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: PLL locked |
| err | output | 1 | One-cycle pulse: range error or wait timeout |
| bus_req | output | 1 | Bus request, held until ready |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid with ready |
| bus_ready | input | 1 | Transfer completes this cycle |

## Verification
The bench targets the range edges: a DCO of exactly 500 and exactly 1000, 2000 rejected, and N=2 where integer division gives 498 and must fail where real division would pass. A design with an off-by-one compare, or with exact division, would pick the wrong speed code or start the script when it should stop. The plain variant is run with an out-of-range DCO and must still finish without any fractional-only writes. A design that gates these wrongly would show a missing or extra transfer in the scoreboard. The status waits are tested with a late acknowledge, a limit of zero, and a lock that never arrives, which catch off-by-one poll counts and transfers issued after an abort. A second `start` mid-run with a different M checks that the latched configuration is kept.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_SETUP, ST_WAIT} seq_state_t;

  typedef enum logic [3:0] {
    OP_RD_CTL, OP_SET_BYP, OP_POLL_BYP, OP_CLR_INIT, OP_M2N, OP_MDIV,
    OP_FRAC, OP_SPEED, OP_PST_ON, OP_PST_OFF, OP_DST_ON, OP_DST_OFF,
    OP_OUTEN, OP_RUN, OP_POLL_LOCK, OP_END
  } op_t;

  localparam logic [7:0]  OFF_CTRL    = 8'h04;
  localparam logic [7:0]  OFF_DIVSTB  = 8'h08;
  localparam logic [7:0]  OFF_POSTSTB = 8'h0C;
  localparam logic [7:0]  OFF_M2N     = 8'h10;
  localparam logic [7:0]  OFF_MDIV    = 8'h14;
  localparam logic [7:0]  OFF_FRAC    = 8'h18;
  localparam logic [7:0]  OFF_STAT    = 8'h24;

  localparam logic [31:0] CTL_BYPASS  = 32'h0080_0000;
  localparam logic [31:0] CTL_INIT    = 32'h0000_0001;
  localparam logic [31:0] CTL_LOOPMD  = 32'h0000_1C00;
  localparam logic [31:0] CTL_OUTEN   = 32'h201A_0000;
  localparam logic [31:0] STAT_BYP    = 32'h0000_0101;
  localparam logic [31:0] STAT_LOCK   = 32'h0000_0600;
  localparam logic [31:0] SPEED_LO    = 32'h0000_0801;
  localparam logic [31:0] SPEED_HI    = 32'h0000_1001;
  localparam logic [31:0] STROBE_OFF  = 32'hFFFF_FFFE;
endpackage

// File: rtl/pllseq_rdiv.sv
module pllseq_rdiv #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quo,
  output logic         fin
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  dvs_q;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted, diff;

  assign shifted = {rem[W-1:0], quo[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      fin <= 1'b0;
      cnt <= '0;
      rem <= '0;
      quo <= '0;
      dvs_q <= '0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem   <= '0;
        quo   <= dividend;
        dvs_q <= divisor;
        cnt   <= CW'(W);
        run   <= 1'b1;
      end else if (run) begin
        if (!diff[W]) begin
          rem <= diff;
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted;
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run <= 1'b0;
          fin <= 1'b1;
        end
      end
    end
  end

  AST_DIV_FIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    fin |=> !fin); // R4
  AST_DIV_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    go |-> !run); // R3
endmodule

// File: rtl/pllseq_math.sv
module pllseq_math #(
  parameter int NW = 8,
  parameter int MW = 12,
  parameter int DW = MW + 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] n,
  input  logic [MW-1:0] m,
  output logic [DW-1:0] dco,
  output logic [7:0]    sigma,
  output logic [31:0]   speed,
  output logic          in_range,
  output logic          fin
);
  typedef enum logic [1:0] {P_IDLE, P_REF, P_MUL, P_SIG} phase_t;

  phase_t        phase;
  logic          div_go, div_fin;
  logic [DW-1:0] div_a, div_b, div_q;
  logic          in_lo, in_hi;

  assign div_go = go || (phase == P_MUL);
  assign div_a  = (phase == P_IDLE) ? DW'(20) : dco + DW'(225);
  assign div_b  = (phase == P_IDLE) ? DW'(n) + DW'(1) : DW'(250);

  pllseq_rdiv #(.W(DW)) u_div (
    .clk(clk), .rst(rst), .go(div_go), .dividend(div_a), .divisor(div_b),
    .quo(div_q), .fin(div_fin)
  );

  assign in_lo    = (dco >= DW'(500))  && (dco < DW'(1000));
  assign in_hi    = (dco >= DW'(1000)) && (dco < DW'(2000));
  assign in_range = in_lo || in_hi;
  assign speed    = in_hi ? pllseq_pkg::SPEED_HI : pllseq_pkg::SPEED_LO;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= P_IDLE;
      dco   <= '0;
      sigma <= '0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (phase)
        P_IDLE: if (go) phase <= P_REF;
        P_REF: if (div_fin) begin
          dco   <= div_q * DW'(m);
          phase <= P_MUL;
        end
        P_MUL: phase <= P_SIG;
        P_SIG: if (div_fin) begin
          sigma <= div_q[7:0];
          fin   <= 1'b1;
          phase <= P_IDLE;
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  AST_SIGMA_SPAN: assert property (@(posedge clk) disable iff (rst)
    fin && in_range |-> (sigma >= 8'd2) && (sigma <= 8'd8)); // R4
endmodule

// File: rtl/pll_prog_seq.sv
module pll_prog_seq #(
  parameter int AW  = 32,
  parameter int NW  = 8,
  parameter int MW  = 12,
  parameter int M2W = 8,
  parameter int TW  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NW-1:0]  cfg_n,
  input  logic [MW-1:0]  cfg_m,
  input  logic [M2W-1:0] cfg_m2,
  input  logic [AW-1:0]  cfg_base,
  input  logic           cfg_frac,
  input  logic [TW-1:0]  cfg_limit,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic           bus_req,
  output logic           bus_we,
  output logic [AW-1:0]  bus_addr,
  output logic [31:0]    bus_wdata,
  input  logic [31:0]    bus_rdata,
  input  logic           bus_ready
);
  import pllseq_pkg::*;
  localparam int DW = MW + 6;

  seq_state_t     state;
  op_t            step;
  logic [NW-1:0]  n_q;
  logic [MW-1:0]  m_q;
  logic [M2W-1:0] m2_q;
  logic [AW-1:0]  base_q;
  logic           frac_q;
  logic [TW-1:0]  lim_q, poll_cnt;
  logic [31:0]    ctrl_sh;
  logic           math_go, math_fin, in_range;
  logic [DW-1:0]  dco;
  logic [7:0]     sigma;
  logic [31:0]    speed;

  logic           op_we, op_skip;
  logic [7:0]     op_off;
  logic [31:0]    op_data, op_mask;

  pllseq_math #(.NW(NW), .MW(MW), .DW(DW)) u_math (
    .clk(clk), .rst(rst), .go(math_go), .n(n_q), .m(m_q),
    .dco(dco), .sigma(sigma), .speed(speed), .in_range(in_range), .fin(math_fin)
  );

  always_comb begin
    op_we = 1'b1; op_skip = 1'b0; op_off = OFF_CTRL; op_data = '0; op_mask = '0;
    case (step)
      OP_RD_CTL:    op_we = 1'b0;
      OP_SET_BYP:   op_data = ctrl_sh | CTL_BYPASS;
      OP_POLL_BYP:  begin op_we = 1'b0; op_off = OFF_STAT; op_mask = STAT_BYP; end
      OP_CLR_INIT:  op_data = ctrl_sh & ~CTL_INIT;
      OP_M2N:       begin op_off = OFF_M2N; op_data = (32'(m2_q) << 16) | 32'(n_q); end
      OP_MDIV:      begin op_off = OFF_MDIV; op_data = 32'(m_q); end
      OP_FRAC:      begin op_off = OFF_FRAC; op_data = {sigma, 24'h0}; op_skip = !frac_q; end
      OP_SPEED:     begin op_data = (ctrl_sh & ~CTL_LOOPMD) | speed; op_skip = !frac_q; end
      OP_PST_ON:    begin op_off = OFF_POSTSTB; op_data = 32'h1; end
      OP_PST_OFF:   begin op_off = OFF_POSTSTB; op_data = STROBE_OFF; end
      OP_DST_ON:    begin op_off = OFF_DIVSTB; op_data = 32'h1; end
      OP_DST_OFF:   begin op_off = OFF_DIVSTB; op_data = STROBE_OFF; end
      OP_OUTEN:     begin op_data = ctrl_sh | CTL_OUTEN; op_skip = !frac_q; end
      OP_RUN:       op_data = (ctrl_sh & ~CTL_BYPASS) | CTL_INIT;
      OP_POLL_LOCK: begin op_we = 1'b0; op_off = OFF_STAT; op_mask = STAT_LOCK; end
      default:      op_skip = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; step <= OP_RD_CTL;
      busy <= 1'b0; done <= 1'b0; err <= 1'b0; math_go <= 1'b0;
      bus_req <= 1'b0; bus_we <= 1'b0; bus_addr <= '0; bus_wdata <= '0;
      n_q <= '0; m_q <= '0; m2_q <= '0; base_q <= '0; frac_q <= 1'b0;
      lim_q <= '0; poll_cnt <= '0; ctrl_sh <= '0;
    end else begin
      done <= 1'b0; err <= 1'b0; math_go <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          n_q <= cfg_n; m_q <= cfg_m; m2_q <= cfg_m2; base_q <= cfg_base;
          frac_q <= cfg_frac; lim_q <= cfg_limit; poll_cnt <= '0;
          busy <= 1'b1; math_go <= 1'b1; state <= ST_CALC;
        end
        ST_CALC: if (math_fin) begin
          if (frac_q && !in_range) begin
            err <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
          end else begin
            step <= OP_RD_CTL; state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (step == OP_END) begin
            done <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
          end else if (op_skip) begin
            step <= op_t'(4'(step) + 4'd1);
          end else begin
            bus_req <= 1'b1; bus_we <= op_we;
            bus_addr <= base_q + AW'(op_off); bus_wdata <= op_data;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: if (bus_ready) begin
          bus_req <= 1'b0;
          state   <= ST_SETUP;
          if (op_we) begin
            if (op_off == OFF_CTRL) ctrl_sh <= op_data;
            step <= op_t'(4'(step) + 4'd1);
          end else if (step == OP_RD_CTL) begin
            ctrl_sh <= bus_rdata;
            step <= op_t'(4'(step) + 4'd1);
          end else if ((bus_rdata & op_mask) == op_mask) begin
            poll_cnt <= '0;
            step <= op_t'(4'(step) + 4'd1);
          end else if (({1'b0, poll_cnt} + 1'b1) >= {1'b0, lim_q}) begin
            err <= 1'b1; busy <= 1'b0; state <= ST_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_wdata) && $stable(bus_we)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_req); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R12
  AST_END_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(done && err) && !((done || err) && busy)); // R12
  AST_FRAC_ONLY: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_we && (bus_addr == base_q + AW'(OFF_FRAC)) |-> frac_q); // R7
endmodule

// File: tb/pll_prog_seq_tb.sv
module pll_prog_seq_tb;
  localparam int AW = 32, NW = 8, MW = 12, M2W = 8, TW = 16;

  typedef struct packed { logic we; logic [31:0] addr; logic [31:0] data; } xact_t;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [NW-1:0] cfg_n = '0;
  logic [MW-1:0] cfg_m = '0;
  logic [M2W-1:0] cfg_m2 = '0;
  logic [AW-1:0] cfg_base = '0;
  logic cfg_frac = 1'b0;
  logic [TW-1:0] cfg_limit = '0;
  logic busy, done, err, bus_req, bus_we, bus_ready;
  logic [AW-1:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, fails = 0;
  xact_t exp_q[$];

  logic [31:0] m_ctrl = '0;
  int byp_delay = 0, lock_delay = 0, byp_seen = 0, lock_seen = 0;

  always #5 clk = ~clk;

  pll_prog_seq #(.AW(AW), .NW(NW), .MW(MW), .M2W(M2W), .TW(TW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .cfg_n(cfg_n), .cfg_m(cfg_m),
    .cfg_m2(cfg_m2), .cfg_base(cfg_base), .cfg_frac(cfg_frac), .cfg_limit(cfg_limit),
    .busy(busy), .done(done), .err(err), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  // behavioural PLL register window
  always @(posedge clk) begin
    if (rst) begin
      bus_ready <= 1'b0; bus_rdata <= '0;
    end else if (bus_req && !bus_ready) begin
      bus_ready <= 1'b1;
      if (bus_we) begin
        if (bus_addr == cfg_base + 32'h04) m_ctrl = bus_wdata;
      end else if (bus_addr == cfg_base + 32'h04) begin
        bus_rdata <= m_ctrl;
      end else if (bus_addr == cfg_base + 32'h24) begin
        if (m_ctrl[23]) begin
          if (byp_seen >= byp_delay) bus_rdata <= 32'h101;
          else begin byp_seen = byp_seen + 1; bus_rdata <= 32'h100; end
        end else if (m_ctrl[0]) begin
          if (lock_seen >= lock_delay) bus_rdata <= 32'h600;
          else begin lock_seen = lock_seen + 1; bus_rdata <= 32'h200; end
        end else bus_rdata <= 32'h0;
      end else bus_rdata <= 32'h0;
    end else bus_ready <= 1'b0;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && bus_req && bus_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R10 unexpected transfer", bus_addr, 32'h0);
      end else begin
        xact_t e;
        e = exp_q.pop_front();
        chk(bus_we == e.we && bus_addr == e.addr && (!e.we || bus_wdata == e.data),
            "R5-R9 bus op", bus_we ? bus_wdata : bus_addr, e.we ? e.data : e.addr);
      end
    end
  end

  task automatic push(input logic we, input logic [31:0] addr, input logic [31:0] data);
    xact_t x;
    x.we = we; x.addr = addr; x.data = data;
    exp_q.push_back(x);
  endtask

  // kind: outcome expected; returns by checking flags
  task automatic run_case(input string name, input bit frac, input int n, input int m, input int m2,
                          input int bd, input int ld, input int lim, input logic [31:0] c0,
                          input bit poke);
    int dco, sig, reads, eff;
    logic [31:0] spd, c, base;
    bit range_ok, exp_err, got_done, got_err;
    base = 32'h4000_0100;
    dco = (20 / (n + 1)) * m;
    range_ok = (dco >= 500 && dco < 2000);
    spd = (dco >= 1000) ? 32'h1001 : 32'h801;
    sig = (dco + 225) / 250;
    eff = (lim < 1) ? 1 : lim;
    exp_err = 1'b0;
    if (frac && !range_ok) exp_err = 1'b1; // R3 no bus op at all
    else begin
      push(0, base + 4, 0);                                   // R5
      c = c0 | 32'h0080_0000; push(1, base + 4, c);
      reads = (bd >= eff) ? eff : bd + 1;
      repeat (reads) push(0, base + 32'h24, 0);
      if (bd >= eff) exp_err = 1'b1;                          // R10
      else begin
        c = c & ~32'h1; push(1, base + 4, c);                 // R6
        push(1, base + 32'h10, (32'(m2) << 16) | 32'(n));
        push(1, base + 32'h14, 32'(m));
        if (frac) begin                                       // R7, R4
          push(1, base + 32'h18, {sig[7:0], 24'h0});
          c = (c & ~32'h1C00) | spd; push(1, base + 4, c);
        end
        push(1, base + 32'h0C, 32'h1); push(1, base + 32'h0C, 32'hFFFF_FFFE); // R8
        push(1, base + 32'h08, 32'h1); push(1, base + 32'h08, 32'hFFFF_FFFE);
        if (frac) begin c = c | 32'h201A_0000; push(1, base + 4, c); end     // R9
        c = (c & ~32'h0080_0000) | 32'h1; push(1, base + 4, c);
        reads = (ld >= eff) ? eff : ld + 1;
        repeat (reads) push(0, base + 32'h24, 0);
        if (ld >= eff) exp_err = 1'b1;
      end
    end
    m_ctrl = c0; byp_delay = bd; lock_delay = ld; byp_seen = 0; lock_seen = 0;
    cfg_frac = frac; cfg_n = NW'(n); cfg_m = MW'(m); cfg_m2 = M2W'(m2);
    cfg_base = base; cfg_limit = TW'(lim);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", {31'b0, busy}, 32'h1);
    if (poke) begin // R2 start ignored while busy
      repeat (15) @(negedge clk);
      cfg_m = MW'(m + 7); cfg_frac = ~frac; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    got_done = 1'b0; got_err = 1'b0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (done || err) begin got_done = done; got_err = err; break; end
    end
    chk(got_err == exp_err && got_done == !exp_err, {"R3/R10 outcome ", name},
        {30'b0, got_done, got_err}, {30'b0, !exp_err, exp_err});
    chk(busy == 1'b0, "R12 busy low at end", {31'b0, busy}, 32'h0);
    @(negedge clk);
    chk(!done && !err, "R12 single pulse", {30'b0, done, err}, 32'h0);
    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && !bus_req, {"R10 script complete ", name}, exp_q.size(), 32'h0);
    if (!exp_err) chk(m_ctrl == c, {"R9 final control ", name}, m_ctrl, c);
    exp_q.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !bus_req, "R1 reset state", {28'b0, busy, done, err, bus_req}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !bus_req, "R1 idle after reset", {30'b0, busy, bus_req}, 32'h0);
    run_case("frac 880",      1, 19, 880, 4, 2, 3, 8, 32'h0000_1C01, 0); // R3 0x801, R4 sig 4
    run_case("frac 666",      1, 19, 666, 2, 0, 0, 8, 32'h0000_0000, 0); // R4 sig 3
    run_case("frac 1200",     1, 0, 60, 1, 0, 1, 8, 32'h0000_1C00, 0);   // R3 0x1001 sig 5
    run_case("plain 600",     0, 1, 60, 1, 1, 1, 8, 32'h0000_0001, 0);   // R7 skipped
    run_case("plain 4000",    0, 0, 200, 1, 0, 0, 8, 32'h0000_0000, 0);  // R3 no range check
    run_case("edge 500",      1, 0, 25, 1, 0, 0, 8, 32'h0000_0000, 0);   // R3 low edge, sig 2
    run_case("edge 1000",     1, 0, 50, 1, 0, 0, 8, 32'h0000_0000, 0);   // R3 0x1001 edge
    run_case("edge 2000",     1, 0, 100, 1, 0, 0, 8, 32'h0000_0000, 0);  // R3 error
    run_case("intdiv 498",    1, 2, 83, 1, 0, 0, 8, 32'h0000_0000, 0);   // R3 integer ref
    run_case("byp timeout",   1, 19, 880, 4, 20, 0, 3, 32'h0000_0000, 0);// R10
    run_case("lock timeout",  1, 19, 880, 4, 0, 50, 4, 32'h0000_0000, 0);// R10
    run_case("limit zero",    0, 1, 60, 1, 5, 0, 0, 32'h0000_0000, 0);   // R10
    run_case("restart poke",  1, 19, 880, 4, 1, 1, 8, 32'h0000_0000, 1); // R2
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule